// File: doc/BRIEF.md
# Video Mode Table with Priority Matching

This block stores a small table of video-mode descriptors. Each descriptor holds an active width, an active height, a total line length and a total frame length, and it carries its own valid flag. A host writes and reads the table through a simple register port. When a resolution is presented on the request inputs, the block searches the valid entries, selects the lowest-numbered entry whose active width and height both match, and records that index in a status register. Whenever the selected index changes, the block raises a one-cycle update strobe.

The timing outputs of the block come from a shadow copy of the selected descriptor. That copy reloads only at a start-of-frame pulse, and only while the selected entry is valid. A host can therefore edit the descriptor that is currently in use without disturbing the live output: it clears the valid flag, rewrites the fields, then sets the valid flag again. With the banked option enabled, descriptor writes go to the entry named by a bank-select register, and the entry bits of the write address are ignored.

Top module: `vmode_table`

## Requirements
- R1: After reset, every valid flag is 0, the selected index is 0, the no-match bit is 0, the update strobe is 0, and all four active timing outputs are 0.
- R2: Each descriptor field can be written and read back through the host port. Address bit 6 = 0 selects the table, bits 5:3 give the entry and bits 2:0 give the field: 0 width, 1 height, 2 line total, 3 frame total, 4 valid (data bit 0).
- R3: When a request is presented, the lowest-numbered valid entry whose width and height both match becomes the selected index one cycle later.
- R4: An entry with a cleared valid flag never matches, whatever its stored fields hold.
- R5: Clearing a valid flag leaves that entry's stored fields unchanged, and they read back as before.
- R6: A request that matches no valid entry keeps the previous selected index and sets the no-match bit. The next request that matches clears the bit.
- R7: The update strobe is high for exactly one cycle after a request that selects a different index, or after the first successful match since reset. It stays low when the same index is selected again and when nothing matches.
- R8: The active timing outputs change only in the cycle after a start-of-frame pulse, and only if the selected entry is valid at that pulse. They then take that entry's fields.
- R9: With banking enabled, a table write goes to the entry held in the bank-select register (global field 0, address bit 6 = 1) and the entry bits of the address are ignored. The bank-select value reads back.
- R10: Global field 1 reads the status as the selected index in bits 2:0 and the no-match bit in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 7 | Host address {global, entry, field} |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, combinational from address |
| req_valid_i | input | 1 | Resolution request present |
| req_width_i | input | 16 | Requested active width |
| req_height_i | input | 16 | Requested active height |
| sof_i | input | 1 | Start-of-frame pulse |
| mode_idx_o | output | 3 | Selected entry index |
| no_match_o | output | 1 | Last request found no valid entry |
| status_upd_o | output | 1 | One-cycle strobe when the selection changes |
| act_width_o | output | 16 | Active width in use |
| act_height_o | output | 16 | Active height in use |
| act_line_o | output | 16 | Line total in use |
| act_frame_o | output | 16 | Frame total in use |

## Verification
The bench builds the block with its defaults: eight entries, 16-bit fields and banking enabled. Eight entries give room for two resolutions that each appear in two entries, so priority and fall-through to a higher entry can both be shown. Because banking is on, every write goes through the bank register, and one write whose address names a different entry shows that the address entry bits are ignored. The path without banking is not exercised.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
  localparam int VM_FW = 16;
  localparam int VM_FSEL_W = 3;

  typedef struct packed {
    logic [VM_FW-1:0] width;
    logic [VM_FW-1:0] height;
    logic [VM_FW-1:0] line_len;
    logic [VM_FW-1:0] frame_len;
  } mode_cfg_t;

  typedef enum logic [VM_FSEL_W-1:0] {
    F_WIDTH  = 3'd0,
    F_HEIGHT = 3'd1,
    F_LINE   = 3'd2,
    F_FRAME  = 3'd3,
    F_VALID  = 3'd4
  } fsel_e;

  localparam logic [VM_FSEL_W-1:0] G_BANK   = 3'd0;
  localparam logic [VM_FSEL_W-1:0] G_STATUS = 3'd1;
endpackage

// File: rtl/vmode_regs.sv
module vmode_regs
  import vmode_pkg::*;
#(
  parameter int N_MODES = 8,
  parameter bit BANKED  = 1'b1,
  localparam int IDX_W  = $clog2(N_MODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 glob_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [VM_FSEL_W-1:0] fsel_i,
  input  logic [VM_FW-1:0]     wdata_i,
  output mode_cfg_t            cfg_o [N_MODES],
  output logic [N_MODES-1:0]   vld_o,
  output logic [IDX_W-1:0]     bank_o
);
  logic [IDX_W-1:0] tgt;

  generate
    if (BANKED) begin : g_bank
      assign tgt = bank_o;
    end else begin : g_flat
      assign tgt = idx_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_o <= '0;
    else if (we_i && glob_i && fsel_i == G_BANK) bank_o <= wdata_i[IDX_W-1:0];
  end

  for (genvar e = 0; e < N_MODES; e++) begin : g_ent
    logic hit;
    assign hit = we_i && !glob_i && (tgt == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[e] <= '0;
        vld_o[e] <= 1'b0;
      end else if (hit) begin
        case (fsel_i)
          F_WIDTH:  cfg_o[e].width     <= wdata_i;
          F_HEIGHT: cfg_o[e].height    <= wdata_i;
          F_LINE:   cfg_o[e].line_len  <= wdata_i;
          F_FRAME:  cfg_o[e].frame_len <= wdata_i;
          F_VALID:  vld_o[e]           <= wdata_i[0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vmode_prio.sv
module vmode_prio
  import vmode_pkg::*;
#(
  parameter int N_MODES = 8,
  localparam int IDX_W  = $clog2(N_MODES)
) (
  input  mode_cfg_t          cfg_i [N_MODES],
  input  logic [N_MODES-1:0] vld_i,
  input  logic [VM_FW-1:0]   width_i,
  input  logic [VM_FW-1:0]   height_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [N_MODES-1:0] match;

  for (genvar e = 0; e < N_MODES; e++) begin : g_cmp
    assign match[e] = vld_i[e] && cfg_i[e].width == width_i
                      && cfg_i[e].height == height_i;
  end

  // scan high to low so the lowest match is the last written
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_MODES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vmode_sel.sv
module vmode_sel
  import vmode_pkg::*;
#(
  parameter int N_MODES = 8,
  localparam int IDX_W  = $clog2(N_MODES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   hit_idx_i,
  input  logic               sof_i,
  input  mode_cfg_t          cfg_i [N_MODES],
  input  logic [N_MODES-1:0] vld_i,
  output logic [IDX_W-1:0]   sel_o,
  output logic               no_match_o,
  output logic               upd_o,
  output logic               have_sel_o,
  output mode_cfg_t          shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      no_match_o <= 1'b0;
      upd_o      <= 1'b0;
      have_sel_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (req_i) begin
        if (hit_i) begin
          sel_o      <= hit_idx_i;
          no_match_o <= 1'b0;
          have_sel_o <= 1'b1;
          upd_o      <= !have_sel_o || (hit_idx_i != sel_o);
        end else begin
          no_match_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_o <= '0;
    else if (sof_i && vld_i[sel_o]) shadow_o <= cfg_i[sel_o];
  end
endmodule

// File: rtl/vmode_table.sv
module vmode_table
  import vmode_pkg::*;
#(
  parameter int N_MODES = 8,
  parameter bit BANKED  = 1'b1,
  localparam int IDX_W  = $clog2(N_MODES),
  localparam int AW     = 1 + IDX_W + VM_FSEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [VM_FW-1:0] host_wdata_i,
  output logic [VM_FW-1:0] host_rdata_o,
  input  logic             req_valid_i,
  input  logic [VM_FW-1:0] req_width_i,
  input  logic [VM_FW-1:0] req_height_i,
  input  logic             sof_i,
  output logic [IDX_W-1:0] mode_idx_o,
  output logic             no_match_o,
  output logic             status_upd_o,
  output logic [VM_FW-1:0] act_width_o,
  output logic [VM_FW-1:0] act_height_o,
  output logic [VM_FW-1:0] act_line_o,
  output logic [VM_FW-1:0] act_frame_o
);
  logic                 a_glob;
  logic [IDX_W-1:0]     a_idx;
  logic [VM_FSEL_W-1:0] a_fsel;
  assign {a_glob, a_idx, a_fsel} = host_addr_i;

  mode_cfg_t          cfg [N_MODES];
  logic [N_MODES-1:0] vld;
  logic [IDX_W-1:0]   bank_q;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               have_sel_q;
  mode_cfg_t          shadow;

  vmode_regs #(.N_MODES(N_MODES), .BANKED(BANKED)) u_regs (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .glob_i(a_glob), .idx_i(a_idx), .fsel_i(a_fsel),
    .wdata_i(host_wdata_i), .cfg_o(cfg), .vld_o(vld), .bank_o(bank_q)
  );

  vmode_prio #(.N_MODES(N_MODES)) u_prio (
    .cfg_i(cfg), .vld_i(vld), .width_i(req_width_i), .height_i(req_height_i),
    .hit_o(hit), .idx_o(hit_idx)
  );

  vmode_sel #(.N_MODES(N_MODES)) u_sel (
    .clk_i, .rst_ni, .req_i(req_valid_i), .hit_i(hit), .hit_idx_i(hit_idx),
    .sof_i, .cfg_i(cfg), .vld_i(vld), .sel_o(mode_idx_o),
    .no_match_o, .upd_o(status_upd_o), .have_sel_o(have_sel_q), .shadow_o(shadow)
  );

  assign act_width_o  = shadow.width;
  assign act_height_o = shadow.height;
  assign act_line_o   = shadow.line_len;
  assign act_frame_o  = shadow.frame_len;

  always_comb begin
    host_rdata_o = '0;
    if (a_glob) begin
      case (a_fsel)
        G_BANK:   host_rdata_o = VM_FW'(bank_q);
        G_STATUS: host_rdata_o = VM_FW'({no_match_o, mode_idx_o});
        default:  ;
      endcase
    end else begin
      case (a_fsel)
        F_WIDTH:  host_rdata_o = cfg[a_idx].width;
        F_HEIGHT: host_rdata_o = cfg[a_idx].height;
        F_LINE:   host_rdata_o = cfg[a_idx].line_len;
        F_FRAME:  host_rdata_o = cfg[a_idx].frame_len;
        F_VALID:  host_rdata_o = VM_FW'(vld[a_idx]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vmode_table_chk.sv
module vmode_table_chk #(
  parameter int IDX_W = 3,
  parameter int FW    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             sof_i,
  input logic [IDX_W-1:0] mode_idx_o,
  input logic             no_match_o,
  input logic             status_upd_o,
  input logic             have_sel,
  input logic [4*FW-1:0]  act_all
);
  // R7
  upd_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_upd_o |-> $past(req_valid_i));

  // R7
  upd_means_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_upd_o && $past(have_sel)) |-> mode_idx_o != $past(mode_idx_o));

  // R6
  miss_keeps_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_valid_i) && no_match_o) |-> mode_idx_o == $past(mode_idx_o));

  // R6
  idle_holds_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> ($stable(mode_idx_o) && $stable(no_match_o) && !status_upd_o));

  // R8
  act_only_at_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sof_i) |-> $stable(act_all));
endmodule

bind vmode_table vmode_table_chk #(.IDX_W(IDX_W), .FW(vmode_pkg::VM_FW)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .sof_i, .mode_idx_o, .no_match_o, .status_upd_o,
  .have_sel(have_sel_q),
  .act_all({act_width_o, act_height_o, act_line_o, act_frame_o})
);

// File: tb/vmode_table_tb.sv
module vmode_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req = 1'b0;
  logic [15:0] req_w = '0;
  logic [15:0] req_h = '0;
  logic        sof = 1'b0;
  logic [2:0]  idx;
  logic        nomatch, upd;
  logic [15:0] aw, ah, al, af;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmode_table u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .req_valid_i(req),
    .req_width_i(req_w), .req_height_i(req_h), .sof_i(sof),
    .mode_idx_o(idx), .no_match_o(nomatch), .status_upd_o(upd),
    .act_width_o(aw), .act_height_o(ah), .act_line_o(al), .act_frame_o(af)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ta(input int e, input int f);
    return {1'b0, 3'(e), 3'(f)};
  endfunction

  function automatic logic [AW-1:0] ga(input int f);
    return {1'b1, 3'b000, 3'(f)};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input int d);
    addr = a; wdata = 16'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int d);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic set_mode(input int e, input int w, input int h, input int l, input int f, input int v);
    wr(ga(0), e);
    wr(ta(e, 0), w); wr(ta(e, 1), h); wr(ta(e, 2), l); wr(ta(e, 3), f);
    wr(ta(e, 4), v);
  endtask

  task automatic set_valid(input int e, input int v);
    wr(ga(0), e);
    wr(ta(e, 4), v);
  endtask

  // request at negedge; state sampled one edge later; strobe gone one edge after that
  task automatic request(input int w, input int h, output int got_idx, output int got_nm,
                         output int got_upd);
    req_w = 16'(w); req_h = 16'(h); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    got_idx = int'(idx); got_nm = int'(nomatch); got_upd = int'(upd);
    @(negedge clk);
    chk(upd == 1'b0, "R7 strobe one cycle", int'(upd), 0);
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic t_reset();
    int d;
    chk(idx == 0, "R1 idx", int'(idx), 0);
    chk(nomatch == 0, "R1 no_match", int'(nomatch), 0);
    chk(upd == 0, "R1 strobe", int'(upd), 0);
    chk({aw, ah, al, af} == '0, "R1 active outputs", int'(aw), 0);
    rd(ta(4, 4), d);
    chk(d == 0, "R1 valid flag", d, 0);
  endtask

  task automatic t_regs();
    int d;
    set_mode(1, 1920, 1080, 2200, 1125, 1);
    set_mode(3, 1280, 720, 1650, 750, 1);
    set_mode(5, 1920, 1080, 2640, 1125, 1);
    set_mode(6, 1280, 720, 1980, 750, 1);
    set_mode(2, 1920, 1080, 2000, 1100, 0);
    rd(ta(1, 2), d); chk(d == 2200, "R2 line readback", d, 2200);
    rd(ta(3, 3), d); chk(d == 750, "R2 frame readback", d, 750);
    rd(ta(6, 0), d); chk(d == 1280, "R2 width readback", d, 1280);
    rd(ta(5, 4), d); chk(d == 1, "R2 valid readback", d, 1);
  endtask

  task automatic t_priority();
    int i, n, u;
    request(1920, 1080, i, n, u);
    chk(i == 1, "R3 lowest of 1,5 (R4 skips invalid 2 anyway)", i, 1);
    chk(u == 1, "R7 first match strobe", u, 1);
    request(1280, 720, i, n, u);
    chk(i == 3, "R3 lowest of 3,6", i, 3);
    chk(u == 1, "R7 change strobe", u, 1);
    request(1280, 720, i, n, u);
    chk(i == 3 && u == 0, "R7 same index no strobe", u, 0);
  endtask

  task automatic t_nomatch();
    int i, n, u, d;
    request(640, 480, i, n, u);
    chk(i == 3, "R6 index kept", i, 3);
    chk(n == 1, "R6 no_match set", n, 1);
    chk(u == 0, "R7 no strobe on miss", u, 0);
    rd(ga(1), d);
    chk(d == 'h0B, "R10 status word", d, 'h0B);
    request(1280, 720, i, n, u);
    chk(n == 0, "R6 no_match cleared", n, 0);
  endtask

  task automatic t_invalidate();
    int i, n, u, d;
    set_valid(1, 0);
    request(1920, 1080, i, n, u);
    chk(i == 5, "R4 invalid 1 skipped", i, 5);
    rd(ta(1, 0), d); chk(d == 1920, "R5 width kept", d, 1920);
    rd(ta(1, 2), d); chk(d == 2200, "R5 line kept", d, 2200);
    rd(ga(1), d); chk(d == 5, "R10 status word", d, 5);
  endtask

  task automatic t_shadow();
    chk(aw == 0, "R8 no load without sof", int'(aw), 0);
    pulse_sof();
    chk(aw == 1920 && al == 2640, "R8 load at sof", int'(al), 2640);
    set_valid(5, 0);
    wr(ta(5, 0), 3840); wr(ta(5, 2), 4400);
    chk(al == 2640, "R8 edit without sof", int'(al), 2640);
    pulse_sof();
    chk(aw == 1920 && al == 2640, "R8 invalid at sof holds", int'(aw), 1920);
    wr(ta(5, 4), 1);
    repeat (3) @(negedge clk);
    chk(aw == 1920, "R8 revalid waits for sof", int'(aw), 1920);
    pulse_sof();
    chk(aw == 3840 && al == 4400, "R8 new config at sof", int'(aw), 3840);
    chk(ah == 1080 && af == 1125, "R8 other fields", int'(af), 1125);
  endtask

  task automatic t_bank();
    int d;
    wr(ga(0), 2);
    rd(ga(0), d); chk(d == 2, "R9 bank readback", d, 2);
    wr(ta(7, 0), 777);
    rd(ta(2, 0), d); chk(d == 777, "R9 write to banked entry", d, 777);
    rd(ta(7, 0), d); chk(d == 0, "R9 address entry ignored", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_priority();
    t_nomatch();
    t_invalidate();
    t_shadow();
    t_bank();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule